// File: doc/BRIEF.md
# Interrupt Priority Resolution Core

This block keeps the per-vector request, in-service and trigger-mode state of one local interrupt controller, with 256 vectors. Sources raise a vector together with its trigger mode. The core resolves which pending vector should interrupt the processor. The processor priority is formed from the task priority and the class of the highest vector already in service, where a class is a group of 16 vectors. The result drives a registered pending line to the CPU.

The CPU takes an interrupt through an acknowledge request. The response comes one cycle later and is one of three things:
- the granted vector, which moves from pending to in-service;
- the programmed spurious vector, when the best candidate is held back by priority;
- "none", when nothing is pending or the controller is software-disabled.

An end-of-interrupt retires the highest in-service vector. When the retired vector was level-triggered, the core also emits a one-cycle broadcast carrying that vector, so upstream level sources can re-sample.

Top module: `irq_prio_core`

## Requirements
- R1: After reset no vector is pending or in service, the task priority is 0, `ppr_o` is 0, `irq_pending_o` is low and the controller is disabled.
- R2: A raise sets the vector's request bit. Its trigger bit is set when `raise_level_i` is 1 and cleared when it is 0, and a later raise of the same vector overwrites that trigger bit.
- R3: Among pending vectors, the numerically highest is the one granted.
- R4: `ppr_o` equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector; otherwise it equals that nibble followed by four zero bits. An empty in-service set counts as vector 0.
- R5: A candidate is masked when `ppr_o` is non-zero and the candidate's upper nibble is at most `ppr_o[7:4]`. An acknowledge of a masked candidate returns the spurious vector with `ack_spur_o` = 1 and changes no state.
- R6: An acknowledge of an unmasked candidate returns it with `ack_none_o` = `ack_spur_o` = 0, clears its request bit and sets its in-service bit. The acknowledge response is valid exactly one cycle after the request.
- R7: An end-of-interrupt clears the highest in-service bit. It pulses `eoi_bcast_o` with that vector on `eoi_bcast_vec_o` one cycle later only if the vector's trigger bit is set and directed EOI is off. With an empty in-service set it does nothing.
- R8: While the enable bit is 0, `irq_pending_o` is low and an acknowledge returns `ack_none_o` = 1 with vector 0. The same "none" answer applies when no vector is pending.
- R9: A spurious-register write keeps bits 7:0 as the spurious vector, bit 8 as the enable and bit 12 as directed EOI, and discards all other bits. A nibble task-priority write stores its value shifted left by 4. When both task-priority writes come in the same cycle, the full-byte write wins.
- R10: `irq_pending_o` is registered: it reflects the grant condition of the state one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raise_valid_i | input | 1 | Raise strobe |
| raise_vec_i | input | 8 | Vector being raised |
| raise_level_i | input | 1 | 1 = level-triggered, 0 = edge |
| tpr_wr_i | input | 1 | Full-byte task priority write |
| tpr_wr_data_i | input | 8 | Full task priority value |
| tpr_cr_wr_i | input | 1 | Nibble task priority write |
| tpr_cr_data_i | input | 4 | Priority nibble, stored in bits 7:4 |
| svr_wr_i | input | 1 | Spurious register write |
| svr_wr_data_i | input | 16 | Spurious register value |
| eoi_i | input | 1 | End-of-interrupt strobe |
| ack_req_i | input | 1 | Acknowledge request |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_vec_o | output | 8 | Granted or spurious vector |
| ack_spur_o | output | 1 | Response is the spurious vector |
| ack_none_o | output | 1 | No vector available |
| irq_pending_o | output | 1 | Interrupt request to the CPU |
| eoi_bcast_o | output | 1 | Level EOI broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector of the broadcast |
| ppr_o | output | 8 | Current processor priority |

## Verification
The bench targets the class boundary.

- A candidate in the same 16-vector class as the in-service vector must come back as spurious. A design that compares full vectors, or uses `<` instead of `<=`, would grant it.
- The bench repeats a masked acknowledge. A design that changes state on a spurious answer would later lose or duplicate a vector.
- It re-raises a level vector as edge. A design that only sets the trigger bit would wrongly broadcast on the next end-of-interrupt.
- It checks that directed EOI suppresses the broadcast, and that an end-of-interrupt with an empty in-service set is harmless.
- It disables the controller while a vector is still pending. `irq_pending_o` must drop and acknowledge must return "none" rather than the vector.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int CLS_W       = 4;
  localparam int SVR_W       = 16;
  localparam int SVR_EN_BIT  = 8;
  localparam int SVR_DIR_BIT = 12;
  localparam logic [7:0] SPUR_RST = 8'hFF;
endpackage

// File: rtl/irq_msb_enc.sv
module irq_msb_enc #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) idx_o = W'(i);  // later (higher) index wins
    end
  end
  assign any_o = |bits_i;
endmodule

// File: rtl/irq_ppr_calc.sv
module irq_ppr_calc
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_hi_i,
  output logic [VEC_W-1:0] ppr_o
);
  logic [CLS_W-1:0] isr_cls;
  assign isr_cls = isr_any_i ? isr_hi_i[VEC_W-1 -: CLS_W] : '0;
  assign ppr_o   = (tpr_i[VEC_W-1 -: CLS_W] >= isr_cls) ? tpr_i
                                                        : {isr_cls, {(VEC_W-CLS_W){1'b0}}};
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_valid_i,
  input  logic [VEC_W-1:0] raise_vec_i,
  input  logic             raise_level_i,
  input  logic             tpr_wr_i,
  input  logic [VEC_W-1:0] tpr_wr_data_i,
  input  logic             tpr_cr_wr_i,
  input  logic [CLS_W-1:0] tpr_cr_data_i,
  input  logic             svr_wr_i,
  input  logic [SVR_W-1:0] svr_wr_data_i,
  input  logic             eoi_i,
  input  logic             ack_req_i,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic             ack_spur_o,
  output logic             ack_none_o,
  output logic             irq_pending_o,
  output logic             eoi_bcast_o,
  output logic [VEC_W-1:0] eoi_bcast_vec_o,
  output logic [VEC_W-1:0] ppr_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q, irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0]   tpr_q, spur_vec_q;
  logic               sw_en_q, dir_eoi_q;
  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_hi, isr_hi, ppr;
  logic               masked, grant_ok, ack_grant, eoi_hit;

  irq_msb_enc #(.N(NUM_VEC), .W(VEC_W)) u_irr_enc (
    .bits_i(irr_q), .any_o(irr_any), .idx_o(irr_hi));
  irq_msb_enc #(.N(NUM_VEC), .W(VEC_W)) u_isr_enc (
    .bits_i(isr_q), .any_o(isr_any), .idx_o(isr_hi));
  irq_ppr_calc #(.VEC_W(VEC_W)) u_ppr (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_hi_i(isr_hi), .ppr_o(ppr));

  assign ppr_o     = ppr;
  assign masked    = (ppr != '0) &&
                     (irr_hi[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);
  assign grant_ok  = sw_en_q && irr_any && !masked;
  assign ack_grant = ack_req_i && grant_ok;
  assign eoi_hit   = eoi_i && isr_any;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_grant) begin
      irr_d[irr_hi] = 1'b0;
      isr_d[irr_hi] = 1'b1;
    end
    if (eoi_hit) isr_d[isr_hi] = 1'b0;
    // a new raise wins over a same-cycle grant of that vector
    if (raise_valid_i) begin
      irr_d[raise_vec_i] = 1'b1;
      tmr_d[raise_vec_i] = raise_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q      <= '0;
      spur_vec_q <= VEC_W'(SPUR_RST);
      sw_en_q    <= 1'b0;
      dir_eoi_q  <= 1'b0;
    end else begin
      if (tpr_wr_i)         tpr_q <= tpr_wr_data_i;
      else if (tpr_cr_wr_i) tpr_q <= {tpr_cr_data_i, {(VEC_W-CLS_W){1'b0}}};
      if (svr_wr_i) begin
        spur_vec_q <= svr_wr_data_i[VEC_W-1:0];
        sw_en_q    <= svr_wr_data_i[SVR_EN_BIT];
        dir_eoi_q  <= svr_wr_data_i[SVR_DIR_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o     <= 1'b0;
      ack_vec_o       <= '0;
      ack_spur_o      <= 1'b0;
      ack_none_o      <= 1'b0;
      irq_pending_o   <= 1'b0;
      eoi_bcast_o     <= 1'b0;
      eoi_bcast_vec_o <= '0;
    end else begin
      irq_pending_o <= grant_ok;
      ack_valid_o   <= ack_req_i;
      ack_spur_o    <= 1'b0;
      ack_none_o    <= 1'b0;
      ack_vec_o     <= '0;
      if (ack_req_i) begin
        if (!sw_en_q || !irr_any) begin
          ack_none_o <= 1'b1;
        end else if (masked) begin
          ack_spur_o <= 1'b1;
          ack_vec_o  <= spur_vec_q;
        end else begin
          ack_vec_o  <= irr_hi;
        end
      end
      eoi_bcast_o     <= eoi_hit && tmr_q[isr_hi] && !dir_eoi_q;
      eoi_bcast_vec_o <= eoi_hit ? isr_hi : '0;
    end
  end
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_req_i,
  input logic       eoi_i,
  input logic       ack_valid_o,
  input logic       ack_spur_o,
  input logic       ack_none_o,
  input logic       irq_pending_o,
  input logic       eoi_bcast_o,
  input logic [7:0] ppr_o,
  input logic [7:0] tpr_q,
  input logic       sw_en_q
);
  assert_ppr_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[7:4] >= tpr_q[7:4]);
  assert_ack_kind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $countones({ack_spur_o, ack_none_o}) <= 1);
  assert_ack_timing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ack_req_i));
  assert_bcast_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i));
  assert_disabled_none_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_i && !sw_en_q) |=> (ack_valid_o && ack_none_o));
  assert_pending_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_q |=> !irq_pending_o);
endmodule

bind irq_prio_core irq_prio_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_req_i(ack_req_i), .eoi_i(eoi_i),
  .ack_valid_o(ack_valid_o), .ack_spur_o(ack_spur_o), .ack_none_o(ack_none_o),
  .irq_pending_o(irq_pending_o), .eoi_bcast_o(eoi_bcast_o), .ppr_o(ppr_o),
  .tpr_q(tpr_q), .sw_en_q(sw_en_q));

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic raise_valid = 0, raise_level = 0, tpr_wr = 0, tpr_cr_wr = 0, svr_wr = 0;
  logic eoi = 0, ack_req = 0;
  logic [7:0] raise_vec = 0, tpr_data = 0;
  logic [3:0] tpr_cr_data = 0;
  logic [15:0] svr_data = 0;
  logic ack_valid, ack_spur, ack_none, irq_pending, eoi_bcast;
  logic [7:0] ack_vec, eoi_bcast_vec, ppr;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_prio_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .raise_valid_i(raise_valid), .raise_vec_i(raise_vec), .raise_level_i(raise_level),
    .tpr_wr_i(tpr_wr), .tpr_wr_data_i(tpr_data),
    .tpr_cr_wr_i(tpr_cr_wr), .tpr_cr_data_i(tpr_cr_data),
    .svr_wr_i(svr_wr), .svr_wr_data_i(svr_data),
    .eoi_i(eoi), .ack_req_i(ack_req),
    .ack_valid_o(ack_valid), .ack_vec_o(ack_vec), .ack_spur_o(ack_spur),
    .ack_none_o(ack_none), .irq_pending_o(irq_pending),
    .eoi_bcast_o(eoi_bcast), .eoi_bcast_vec_o(eoi_bcast_vec), .ppr_o(ppr));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic raise(input logic [7:0] v, input logic lvl);
    raise_vec = v; raise_level = lvl; raise_valid = 1; step(); raise_valid = 0;
  endtask

  // kind: 0 none, 1 spurious, 2 grant
  task automatic ack_expect(input string req, input int kind, input logic [7:0] v);
    ack_req = 1; step(); ack_req = 0;
    check({req, " ack_valid"}, ack_valid, 1);
    check({req, " ack_none"}, ack_none, kind == 0);
    check({req, " ack_spur"}, ack_spur, kind == 1);
    check({req, " ack_vec"}, ack_vec, v);
  endtask

  task automatic eoi_expect(input string req, input logic bc, input logic [7:0] v);
    eoi = 1; step(); eoi = 0;
    check({req, " bcast"}, eoi_bcast, bc);
    if (bc) check({req, " bcast_vec"}, eoi_bcast_vec, v);
  endtask

  task automatic wr_svr(input logic [15:0] d);
    svr_data = d; svr_wr = 1; step(); svr_wr = 0;
  endtask

  task automatic t_reset();
    check("R1 pending", irq_pending, 0);
    check("R1 ppr", ppr, 0);
    raise(8'h40, 0); step();
    check("R8 pending while disabled", irq_pending, 0);
    ack_expect("R8 disabled", 0, 8'h00);
  endtask

  task automatic t_order();
    wr_svr(16'hE1AB);  // R9: bit8=1 enable, bit12=0, vector AB
    check("R10 pending one cycle late", irq_pending, 0);
    step();
    check("R10 pending", irq_pending, 1);
    raise(8'h30, 0); raise(8'h91, 0); raise(8'h90, 0);
    ack_expect("R3 highest first", 2, 8'h91);
    check("R4 ppr from isr", ppr, 8'h90);
    check("R6 ppr tracks in-service", ppr, 8'h90);
    ack_expect("R5 same class masked", 1, 8'hAB);
    ack_expect("R5 no state change", 1, 8'hAB);
    step();
    check("R5 pending low when masked", irq_pending, 0);
    eoi_expect("R7 edge no bcast", 0, 8'h00);
    check("R7 isr cleared", ppr, 8'h00);
    ack_expect("R6 next grant", 2, 8'h90);
    eoi_expect("R7 eoi", 0, 8'h00);
    ack_expect("R3 then 40", 2, 8'h40);
    eoi_expect("R7 eoi", 0, 8'h00);
    ack_expect("R3 then 30", 2, 8'h30);
    eoi_expect("R7 eoi", 0, 8'h00);
    ack_expect("R8 empty irr none", 0, 8'h00);
  endtask

  task automatic t_tpr();
    tpr_cr_data = 4'h5; tpr_cr_wr = 1; step(); tpr_cr_wr = 0;
    check("R9 nibble tpr", ppr, 8'h50);
    raise(8'h52, 0);
    ack_expect("R5 tpr masks class 5", 1, 8'hAB);
    raise(8'h61, 0);
    ack_expect("R6 above tpr", 2, 8'h61);
    check("R4 isr over tpr", ppr, 8'h60);
    tpr_data = 8'h7C; tpr_wr = 1; tpr_cr_data = 4'h2; tpr_cr_wr = 1; step();
    tpr_wr = 0; tpr_cr_wr = 0;
    check("R9 byte write wins", ppr, 8'h7C);
    check("R4 tpr over isr", ppr, 8'h7C);
  endtask

  task automatic t_level();
    raise(8'hC3, 1);
    ack_expect("R2 level grant", 2, 8'hC3);
    eoi_expect("R7 level bcast", 1, 8'hC3);
    check("R7 next isr", ppr, 8'h7C);
    wr_svr(16'h11AB);  // directed EOI on
    raise(8'hD0, 1);
    ack_expect("R6 grant D0", 2, 8'hD0);
    eoi_expect("R7 directed no bcast", 0, 8'h00);
    wr_svr(16'h01AB);
    raise(8'hE5, 1); raise(8'hE5, 0);
    ack_expect("R2 grant E5", 2, 8'hE5);
    eoi_expect("R2 trigger overwritten", 0, 8'h00);
    eoi_expect("R7 retire 61", 0, 8'h00);
    eoi_expect("R7 empty isr", 0, 8'h00);
    check("R7 empty isr ppr", ppr, 8'h7C);
  endtask

  task automatic t_disable();
    tpr_data = 8'h00; tpr_wr = 1; step(); tpr_wr = 0;
    step();
    check("R10 pending with 52", irq_pending, 1);
    wr_svr(16'h00AB);
    step();
    check("R8 pending dropped", irq_pending, 0);
    ack_expect("R8 disabled none", 0, 8'h00);
    wr_svr(16'h01AB);
    ack_expect("R8 vector kept", 2, 8'h52);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_ni = 1;
    step();
    t_reset();
    t_order();
    t_tpr();
    t_level();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule